// File: doc/BRIEF.md
# Read Phase Sweep Window Calibrator

This block tunes the phase of the clock that captures read data coming back from an external memory. It moves a phase shifter one step at a time across a full span of one or two memory clock periods. At each position it asks for one test read and records whether the returned data matched. After the last position it looks for the contiguous group of passing positions. It then moves the shifter back to the middle of that group and reports the group's length together with a read latency figure in controller clock cycles.

The phase shifter and the read engine sit outside the block, and each is reached through its own request and acknowledge pair. Calibration fails in two ways, each with its own flag: no position passed, or the passing positions form more than one separate group. A sweep always starts from position 0. If the shifter was left somewhere else by an earlier run, the block first steps it down to 0.

Top module: `phase_sweep_cal`

## Requirements
- R1: After reset, `done`, `rd_req`, `step_req`, `err_none` and `err_multi` are 0, `phase_out` is 0 and `rd_latency` is 0.
- R2: A sweep issues exactly one read per position, with NPOS = STEPS_PER_CYCLE × (SPAN_TWO ? 2 : 1) positions. `rd_req` stays high until a cycle in which `rd_ack` is 1. `rd_pass` is sampled in that same cycle, where 1 means the data was correct.
- R3: Between two reads the block issues one `step_req` pulse with `step_up` = 1, lasting one cycle. It issues no further request until `step_ack` returns, so a sweep takes exactly NPOS−1 forward steps.
- R4: `phase_out` always equals the net number of steps acknowledged since reset (up steps minus down steps), so it matches the shifter position.
- R5: The window is a run of consecutive passing positions. `win_size` reports the length of the first such run.
- R6: On success the final phase is start + (length−1)/2, rounded down. The block reaches it with `step_up` = 0 steps from the last position, and `phase_out` equals it when `done` rises.
- R7: If no position passes, `err_none` = 1, `err_multi` = 0, `done` rises and no return steps are made.
- R8: If two or more separate runs pass, `err_multi` = 1 and `err_none` = 0. Runs touching position 0 and position NPOS−1 count as separate runs. `done` rises and no return steps are made.
- R9: On success `rd_latency` = LAT_BASE + final_phase / STEPS_PER_CYCLE, using integer division.
- R10: `start` is ignored while a sweep is running. `done` stays high until the next accepted `start`, which clears it in the following cycle. A new sweep first steps down to position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a calibration sweep (accepted only when idle) |
| step_req | output | 1 | One-cycle request to move the phase shifter one step |
| step_up | output | 1 | Direction of the requested step: 1 forward, 0 back |
| step_ack | input | 1 | Phase shifter has completed the requested step |
| rd_req | output | 1 | Test read request, held until acknowledged |
| rd_ack | input | 1 | Test read complete; `rd_pass` valid |
| rd_pass | input | 1 | 1 when the test read returned correct data |
| done | output | 1 | Calibration finished (held until next start) |
| phase_out | output | PW | Current shifter position in phase steps |
| win_size | output | SW | Length of the passing window |
| rd_latency | output | LAT_W | Read latency in controller cycles for the final phase |
| err_none | output | 1 | No passing position found |
| err_multi | output | 1 | More than one separate passing run found |

## Verification
The bench builds the block with STEPS_PER_CYCLE = 4 and SPAN_TWO = 1, which gives eight positions. That is small enough to apply all 256 pass/fail patterns back to back without a reset in between. This covers every window start and length, both rounding cases of the centre, runs that touch both ends, and every case with no passing position. Because the runs follow each other, every return-to-zero distance from an earlier final phase is also exercised. The latency division crosses a cycle boundary at centre 4.

// File: rtl/psc_pkg.sv
package psc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEEK_CHK,
        ST_SEEK,
        ST_SEEK_WAIT,
        ST_READ,
        ST_STEP,
        ST_STEP_WAIT,
        ST_EVAL
    } cal_state_e;

    typedef enum logic [1:0] {
        RUNS_NONE = 2'd0,
        RUNS_ONE  = 2'd1,
        RUNS_MANY = 2'd2
    } run_count_e;

    function automatic run_count_e runs_bump(input run_count_e cur);
        case (cur)
            RUNS_NONE: return RUNS_ONE;
            default:   return RUNS_MANY;
        endcase
    endfunction

endpackage

// File: rtl/psc_position.sv
module psc_position #(
    parameter int NPOS = 8,
    localparam int PW = (NPOS > 1) ? $clog2(NPOS) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          inc,
    input  logic          dec,
    output logic [PW-1:0] pos_o,
    output logic          at_last_o
);
    localparam logic [PW-1:0] LAST = PW'(NPOS - 1);

    logic [PW-1:0] pos_q;

    always_ff @(posedge clk) begin
        if (rst)
            pos_q <= '0;
        else if (inc)
            pos_q <= pos_q + PW'(1);
        else if (dec)
            pos_q <= pos_q - PW'(1);
    end

    assign pos_o     = pos_q;
    assign at_last_o = (pos_q == LAST);

    p_no_overrun_r4: assert property (@(posedge clk) disable iff (rst)
        inc |-> (pos_q != LAST));
    p_no_underrun_r4: assert property (@(posedge clk) disable iff (rst)
        dec |-> (pos_q != '0));
    p_pos_range_r4: assert property (@(posedge clk) disable iff (rst)
        pos_q <= LAST);

endmodule

// File: rtl/psc_window.sv
module psc_window
    import psc_pkg::*;
#(
    parameter int NPOS = 8,
    localparam int PW = (NPOS > 1) ? $clog2(NPOS) : 1,
    localparam int SW = $clog2(NPOS + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          sample,
    input  logic          pass,
    input  logic [PW-1:0] pos,
    output run_count_e    runs_o,
    output logic [SW-1:0] len_o,
    output logic [PW-1:0] center_o
);
    run_count_e    runs_q;
    logic          active_q;
    logic [PW-1:0] wstart_q;
    logic [SW-1:0] len_q;
    logic [SW-1:0] half;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            runs_q   <= RUNS_NONE;
            active_q <= 1'b0;
            wstart_q <= '0;
            len_q    <= '0;
        end else if (sample) begin
            active_q <= pass;
            if (pass) begin
                if (!active_q) begin
                    runs_q <= runs_bump(runs_q);
                    if (runs_q == RUNS_NONE) begin
                        wstart_q <= pos;
                        len_q    <= SW'(1);
                    end
                end else if (runs_q == RUNS_ONE) begin
                    len_q <= len_q + SW'(1);
                end
            end
        end
    end

    assign half     = (len_q - SW'(1)) >> 1;
    assign runs_o   = runs_q;
    assign len_o    = len_q;
    assign center_o = wstart_q + PW'(half);

    p_len_bound_r5: assert property (@(posedge clk) disable iff (rst)
        len_q <= SW'(NPOS));
    p_empty_len_r5: assert property (@(posedge clk) disable iff (rst)
        (runs_q == RUNS_NONE) |-> (len_q == '0));
    p_run_starts_r8: assert property (@(posedge clk) disable iff (rst || clr)
        (sample && pass && !active_q && runs_q != RUNS_NONE) |=> (runs_q == RUNS_MANY));

endmodule

// File: rtl/phase_sweep_cal.sv
module phase_sweep_cal
    import psc_pkg::*;
#(
    parameter int STEPS_PER_CYCLE = 4,
    parameter bit SPAN_TWO        = 1'b1,
    parameter int LAT_BASE        = 3,
    parameter int LAT_W           = 6,
    localparam int NPOS = STEPS_PER_CYCLE * (SPAN_TWO ? 2 : 1),
    localparam int PW   = (NPOS > 1) ? $clog2(NPOS) : 1,
    localparam int SW   = $clog2(NPOS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic             step_req,
    output logic             step_up,
    input  logic             step_ack,
    output logic             rd_req,
    input  logic             rd_ack,
    input  logic             rd_pass,
    output logic             done,
    output logic [PW-1:0]    phase_out,
    output logic [SW-1:0]    win_size,
    output logic [LAT_W-1:0] rd_latency,
    output logic             err_none,
    output logic             err_multi
);
    cal_state_e       state_q;
    logic             sweeping_q;
    logic [PW-1:0]    target_q;
    logic             done_q, err_none_q, err_multi_q;
    logic [LAT_W-1:0] lat_q;

    logic             pos_inc, pos_dec, at_last;
    logic [PW-1:0]    pos;
    logic             win_clr, win_sample;
    run_count_e       win_runs;
    logic [SW-1:0]    win_len;
    logic [PW-1:0]    win_center;

    assign pos_inc    = (state_q == ST_STEP_WAIT) && step_ack;
    assign pos_dec    = (state_q == ST_SEEK_WAIT) && step_ack;
    assign win_clr    = (state_q == ST_IDLE) && start;
    assign win_sample = (state_q == ST_READ) && rd_ack;

    psc_position #(.NPOS(NPOS)) u_pos (
        .clk       (clk),
        .rst       (rst),
        .inc       (pos_inc),
        .dec       (pos_dec),
        .pos_o     (pos),
        .at_last_o (at_last)
    );

    psc_window #(.NPOS(NPOS)) u_win (
        .clk      (clk),
        .rst      (rst),
        .clr      (win_clr),
        .sample   (win_sample),
        .pass     (rd_pass),
        .pos      (pos),
        .runs_o   (win_runs),
        .len_o    (win_len),
        .center_o (win_center)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            sweeping_q  <= 1'b0;
            target_q    <= '0;
            done_q      <= 1'b0;
            err_none_q  <= 1'b0;
            err_multi_q <= 1'b0;
            lat_q       <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (start) begin
                    done_q      <= 1'b0;
                    err_none_q  <= 1'b0;
                    err_multi_q <= 1'b0;
                    lat_q       <= '0;
                    sweeping_q  <= 1'b1;
                    target_q    <= '0;
                    state_q     <= ST_SEEK_CHK;
                end
                ST_SEEK_CHK: begin
                    if (pos != target_q)
                        state_q <= ST_SEEK;
                    else if (sweeping_q)
                        state_q <= ST_READ;
                    else begin
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                end
                ST_SEEK:      state_q <= ST_SEEK_WAIT;
                ST_SEEK_WAIT: if (step_ack) state_q <= ST_SEEK_CHK;
                ST_READ: if (rd_ack) state_q <= at_last ? ST_EVAL : ST_STEP;
                ST_STEP:      state_q <= ST_STEP_WAIT;
                ST_STEP_WAIT: if (step_ack) state_q <= ST_READ;
                ST_EVAL: begin
                    sweeping_q <= 1'b0;
                    if (win_runs == RUNS_ONE) begin
                        target_q <= win_center;
                        lat_q    <= LAT_W'(LAT_BASE + int'(win_center) / STEPS_PER_CYCLE);
                        state_q  <= ST_SEEK_CHK;
                    end else begin
                        err_none_q  <= (win_runs == RUNS_NONE);
                        err_multi_q <= (win_runs == RUNS_MANY);
                        done_q      <= 1'b1;
                        state_q     <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign step_req   = (state_q == ST_STEP) || (state_q == ST_SEEK);
    assign step_up    = (state_q == ST_STEP);
    assign rd_req     = (state_q == ST_READ);
    assign done       = done_q;
    assign phase_out  = pos;
    assign win_size   = win_len;
    assign rd_latency = lat_q;
    assign err_none   = err_none_q;
    assign err_multi  = err_multi_q;

    p_one_request_r2: assert property (@(posedge clk) disable iff (rst)
        !(rd_req && step_req));
    p_step_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        step_req |=> !step_req);
    p_flags_excl_r7: assert property (@(posedge clk) disable iff (rst)
        !(err_none && err_multi));
    p_done_at_centre_r6: assert property (@(posedge clk) disable iff (rst)
        ($rose(done) && !err_none && !err_multi) |-> (phase_out == win_center));
    p_quiet_when_done_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> (!rd_req && !step_req));

endmodule

// File: tb/phase_sweep_cal_tb.sv
module phase_sweep_cal_tb;
    localparam int STEPS = 4;
    localparam int NPOS  = 8;
    localparam int BASE  = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic step_req, step_up, step_ack;
    logic rd_req, rd_ack, rd_pass;
    logic done, err_none, err_multi;
    logic [2:0] phase_out;
    logic [3:0] win_size;
    logic [5:0] rd_latency;

    int n_vec = 0;
    int n_bad = 0;
    int mpos = 0;
    int n_reads = 0, n_fwd = 0, n_back = 0;
    logic [NPOS-1:0] pat = '0;
    bit ack_pend = 1'b0;

    always #10 clk = ~clk;

    phase_sweep_cal #(.STEPS_PER_CYCLE(STEPS), .SPAN_TWO(1'b1),
                      .LAT_BASE(BASE), .LAT_W(6)) u_dut (
        .clk(clk), .rst(rst), .start(start),
        .step_req(step_req), .step_up(step_up), .step_ack(step_ack),
        .rd_req(rd_req), .rd_ack(rd_ack), .rd_pass(rd_pass),
        .done(done), .phase_out(phase_out), .win_size(win_size),
        .rd_latency(rd_latency), .err_none(err_none), .err_multi(err_multi)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s pattern=%b actual=%0d expected=%0d", req, pat, act, exp);
        end
    endtask

    // Shifter and read-engine model
    initial begin
        step_ack = 1'b0;
        rd_ack   = 1'b0;
        rd_pass  = 1'b0;
        forever begin
            @(negedge clk);
            if (ack_pend) begin step_ack = 1'b1; ack_pend = 1'b0; end
            else step_ack = 1'b0;
            if (rd_ack) rd_ack = 1'b0;
            else if (rd_req) begin
                rd_ack  = 1'b1;
                rd_pass = pat[mpos];
                n_reads++;
            end
            if (step_req) begin
                if (step_up) begin mpos++; n_fwd++; end
                else begin mpos--; n_back++; end
                ack_pend = 1'b1;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int prev;
        int runs, wst, wlen, cen, back_exp;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(done == 0 && rd_req == 0 && step_req == 0, "R1", int'(done), 0);
        chk(err_none == 0 && err_multi == 0, "R1", int'(err_none), 0);
        chk(phase_out == 0 && rd_latency == 0, "R1", int'(phase_out), 0);

        for (int p = 0; p < 256; p++) begin
            pat = p[NPOS-1:0];
            runs = 0; wst = 0; wlen = 0;
            for (int i = 0; i < NPOS; i++) begin
                if (pat[i] && (i == 0 || !pat[i-1])) begin
                    runs++;
                    if (runs == 1) wst = i;
                end
                if (pat[i] && runs == 1) wlen++;
            end
            cen = (runs == 1) ? wst + (wlen - 1) / 2 : 0;
            prev = mpos;
            n_reads = 0; n_fwd = 0; n_back = 0;

            @(negedge clk); start = 1'b1;
            @(negedge clk); start = 1'b0;
            chk(done == 0, "R10 done cleared by start", int'(done), 0);

            if (p == 60) begin
                repeat (10) @(negedge clk);
                start = 1'b1;
                @(negedge clk); start = 1'b0;
                chk(done == 0, "R10 start ignored while busy", int'(done), 0);
            end

            while (!done) @(negedge clk);

            chk(n_reads == NPOS, "R2 reads per sweep", n_reads, NPOS);
            chk(n_fwd == NPOS - 1, "R3 forward steps", n_fwd, NPOS - 1);
            chk(int'(phase_out) == mpos, "R4 phase matches shifter", int'(phase_out), mpos);
            chk(err_none == (runs == 0), "R7 no-window flag", int'(err_none), int'(runs == 0));
            chk(err_multi == (runs > 1), "R8 multi-window flag", int'(err_multi), int'(runs > 1));
            back_exp = prev + ((runs == 1) ? (NPOS - 1 - cen) : 0);
            chk(n_back == back_exp, "R6 return steps", n_back, back_exp);
            if (runs == 1) begin
                chk(int'(win_size) == wlen, "R5 window size", int'(win_size), wlen);
                chk(int'(phase_out) == cen, "R6 final centre", int'(phase_out), cen);
                chk(int'(rd_latency) == BASE + cen / STEPS, "R9 latency",
                    int'(rd_latency), BASE + cen / STEPS);
            end else begin
                chk(int'(phase_out) == NPOS - 1, "R7 R8 no return on failure",
                    int'(phase_out), NPOS - 1);
            end
            repeat (3) @(negedge clk);
            chk(done == 1, "R10 done held", int'(done), 1);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule